// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the interrupt-acceptance slice of a CPU core that names its working registers through two 4-bit pointers: X selects the data register and P selects the program counter. It steps through a fetch state and an execute state, one machine cycle or more at a time. At the end of each instruction it decides whether a pending interrupt request is taken. Taking one costs a single dedicated machine cycle, the interrupt state. On entry to that state the current X and P are packed into an 8-bit save register T. X and P are then forced to fixed values, and the interrupt enable flag is cleared, so the handler runs with register 1 as its program counter and further requests are masked.

Machine-cycle timing comes from a free-running phase counter outside the block. The last phase of a cycle is where every state change happens. Software reaches the enable flag and the two pointers through simple write strobes. Instruction decode, the datapath and the register file are outside this block. The pins are plain control and status lines. No stream of data passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held and on its release, `state` is fetch (code 2'b00), and `x_ptr`, `p_ptr`, `t_reg` and `ie` are all 0.
- R2: State codes are fetch 2'b00, execute 2'b01 and interrupt 2'b11. `state` changes only on the clock edge where `mc_phase` equals MC_CLKS-1. Fetch lasts one machine cycle and is followed by execute.
- R3: An interrupt is taken only when `int_req`, `ie` and `instr_done` are all high at the last phase of an execute cycle. While `ie` is 0, a held `int_req` never leads to state 2'b11, and the sequencer keeps alternating between fetch and execute.
- R4: On entry to the interrupt state, `t_reg` takes the pre-entry pointers, with X in bits 7:4 and P in bits 3:0.
- R5: On entry to the interrupt state, `x_ptr` becomes 2, `p_ptr` becomes 1 and `ie` becomes 0, all at the same edge where `state` becomes 2'b11.
- R6: The interrupt state lasts exactly MC_CLKS (8) clocks. It is followed by fetch, with `p_ptr` still 1.
- R7: `ie_we` loads `ie_wd` into `ie` on the next edge. If the write falls on the entry edge, the entry wins and `ie` is 0.
- R8: `x_we` and `p_we` load `x_wd` and `p_wd` into the pointers on the next edge. These writes, and `ie_we`, have no effect while `state` is 2'b11, and the forced values win on the entry edge.
- R9: An execute cycle that ends with `instr_done` low is followed by another execute cycle. A pending interrupt waits until the instruction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_phase | input | 3 | Clock index within the machine cycle, from the external counter |
| instr_done | input | 1 | Current instruction completes at the end of this execute cycle |
| int_req | input | 1 | Interrupt request, level |
| ie_we | input | 1 | Write strobe for the interrupt enable flag |
| ie_wd | input | 1 | Value for the interrupt enable flag |
| x_we | input | 1 | Write strobe for the X pointer |
| x_wd | input | 4 | Value for the X pointer |
| p_we | input | 1 | Write strobe for the P pointer |
| p_wd | input | 4 | Value for the P pointer |
| state | output | 2 | Current machine state code |
| x_ptr | output | 4 | X pointer |
| p_ptr | output | 4 | P pointer |
| t_reg | output | 8 | Saved pointers, X high nibble, P low nibble |
| ie | output | 1 | Interrupt enable flag |

## Verification
Each of the three state elements shows at the ports on the clock after it goes wrong.

- **Sequencer state:** a wrong state shows on `state` at once, as a change off the machine-cycle boundary, an interrupt state of the wrong length, or a taken request with `ie` low.
- **Save register:** a wrong pack order or a stale value in T shows on `t_reg` on the first clock of the interrupt state. The sweep covers every X/P pair.
- **Pointers and enable flag:** a write that leaks through during the interrupt state, or that beats the forced values, shows on `x_ptr`, `p_ptr` or `ie` on the next clock.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'b00,
    ST_EXEC  = 2'b01,
    ST_INTR  = 2'b11
  } mstate_t;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cyc_last,
  input  logic    instr_done,
  input  logic    take_ok,
  output mstate_t st,
  output logic    enter,
  output logic    in_s3
);
  mstate_t st_nx;

  // Entry happens only at the close of a completed instruction.
  assign enter = (st == ST_EXEC) && cyc_last && instr_done && take_ok;
  assign in_s3 = (st == ST_INTR);

  always_comb begin
    st_nx = st;
    if (cyc_last) begin
      unique case (st)
        ST_FETCH: st_nx = ST_EXEC;
        ST_EXEC: begin
          if (!instr_done)  st_nx = ST_EXEC;
          else if (take_ok) st_nx = ST_INTR;
          else              st_nx = ST_FETCH;
        end
        ST_INTR:  st_nx = ST_FETCH;
        default:  st_nx = ST_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_FETCH;
    else        st <= st_nx;
  end
endmodule

// File: rtl/irq_seq_ptrs.sv
module irq_seq_ptrs #(
  parameter int PTR_W = 4,
  parameter int INT_X = 2,
  parameter int INT_P = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enter,
  input  logic               in_s3,
  input  logic               x_we,
  input  logic [PTR_W-1:0]   x_wd,
  input  logic               p_we,
  input  logic [PTR_W-1:0]   p_wd,
  output logic [PTR_W-1:0]   x_q,
  output logic [PTR_W-1:0]   p_q,
  output logic [2*PTR_W-1:0] t_q
);
  localparam logic [PTR_W-1:0] FX = PTR_W'(INT_X);
  localparam logic [PTR_W-1:0] FP = PTR_W'(INT_P);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      p_q <= '0;
      t_q <= '0;
    end else if (enter) begin
      // Save the pointers, then force the handler's values.
      t_q <= {x_q, p_q};
      x_q <= FX;
      p_q <= FP;
    end else if (!in_s3) begin
      if (x_we) x_q <= x_wd;
      if (p_we) p_q <= p_wd;
    end
  end
endmodule

// File: rtl/irq_seq_ie.sv
module irq_seq_ie (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic in_s3,
  input  logic we,
  input  logic wd,
  output logic ie_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)               ie_q <= 1'b0;
    else if (enter)           ie_q <= 1'b0;
    else if (we && !in_s3)    ie_q <= wd;
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int PTR_W   = 4,
  parameter int MC_CLKS = 8,
  parameter int INT_X   = 2,
  parameter int INT_P   = 1,
  localparam int PH_W   = $clog2(MC_CLKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PH_W-1:0]    mc_phase,
  input  logic               instr_done,
  input  logic               int_req,
  input  logic               ie_we,
  input  logic               ie_wd,
  input  logic               x_we,
  input  logic [PTR_W-1:0]   x_wd,
  input  logic               p_we,
  input  logic [PTR_W-1:0]   p_wd,
  output logic [1:0]         state,
  output logic [PTR_W-1:0]   x_ptr,
  output logic [PTR_W-1:0]   p_ptr,
  output logic [2*PTR_W-1:0] t_reg,
  output logic               ie
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(MC_CLKS - 1);

  mstate_t st;
  logic    cyc_last, enter, in_s3;

  assign cyc_last = (mc_phase == LAST_PH);
  assign state    = st;

  irq_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cyc_last(cyc_last), .instr_done(instr_done),
    .take_ok(int_req & ie), .st(st), .enter(enter), .in_s3(in_s3)
  );

  irq_seq_ptrs #(.PTR_W(PTR_W), .INT_X(INT_X), .INT_P(INT_P)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .enter(enter), .in_s3(in_s3),
    .x_we(x_we), .x_wd(x_wd), .p_we(p_we), .p_wd(p_wd),
    .x_q(x_ptr), .p_q(p_ptr), .t_q(t_reg)
  );

  irq_seq_ie u_ie (
    .clk(clk), .rst_n(rst_n), .enter(enter), .in_s3(in_s3),
    .we(ie_we), .wd(ie_wd), .ie_q(ie)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int PTR_W   = 4,
  parameter int MC_CLKS = 8,
  parameter int INT_X   = 2,
  parameter int INT_P   = 1,
  localparam int PH_W   = $clog2(MC_CLKS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PH_W-1:0]    mc_phase,
  input logic               instr_done,
  input logic               int_req,
  input logic [1:0]         state,
  input logic [PTR_W-1:0]   x_ptr,
  input logic [PTR_W-1:0]   p_ptr,
  input logic [2*PTR_W-1:0] t_reg,
  input logic               ie
);
  localparam logic [1:0] S_FETCH = 2'b00;
  localparam logic [1:0] S_INTR  = 2'b11;

  logic [PH_W:0] s3_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                s3_cnt <= '0;
    else if (state == S_INTR)  s3_cnt <= s3_cnt + 1'b1;
    else                       s3_cnt <= '0;
  end

  a_r2_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b10);

  a_r2_change_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (state != $past(state)) |-> ($past(mc_phase) == PH_W'(MC_CLKS - 1)));

  a_r3_take_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INTR && $past(state) != S_INTR)
      |-> ($past(ie) && $past(int_req) && $past(instr_done)));

  a_r4_t_packs_pointers: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INTR && $past(state) != S_INTR)
      |-> (t_reg == {$past(x_ptr), $past(p_ptr)}));

  a_r5_forced_values: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INTR && $past(state) != S_INTR)
      |-> (x_ptr == PTR_W'(INT_X) && p_ptr == PTR_W'(INT_P) && !ie));

  a_r6_s3_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INTR) |-> (s3_cnt < (PH_W+1)'(MC_CLKS)));

  a_r6_s3_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_INTR && state != S_INTR)
      |-> (state == S_FETCH && $past(s3_cnt) == (PH_W+1)'(MC_CLKS - 1)));

  a_r8_hold_in_s3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INTR && $past(state) == S_INTR)
      |-> ($stable(x_ptr) && $stable(p_ptr) && $stable(t_reg) && $stable(ie)));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .PTR_W(PTR_W), .MC_CLKS(MC_CLKS), .INT_X(INT_X), .INT_P(INT_P)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mc_phase(mc_phase), .instr_done(instr_done),
  .int_req(int_req), .state(state), .x_ptr(x_ptr), .p_ptr(p_ptr),
  .t_reg(t_reg), .ie(ie)
);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
  localparam logic [1:0] S_FETCH = 2'b00;
  localparam logic [1:0] S_EXEC  = 2'b01;
  localparam logic [1:0] S_INTR  = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ph;
  logic       instr_done = 1'b1, int_req = 1'b0;
  logic       ie_we = 1'b0, ie_wd = 1'b0;
  logic       x_we = 1'b0, p_we = 1'b0;
  logic [3:0] x_wd = '0, p_wd = '0;
  logic [1:0] state;
  logic [3:0] x_ptr, p_ptr;
  logic [7:0] t_reg;
  logic       ie;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  // External machine-cycle counter.
  always_ff @(posedge clk) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph + 3'd1;
  end

  irq_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .mc_phase(ph), .instr_done(instr_done),
    .int_req(int_req), .ie_we(ie_we), .ie_wd(ie_wd), .x_we(x_we), .x_wd(x_wd),
    .p_we(p_we), .p_wd(p_wd), .state(state), .x_ptr(x_ptr), .p_ptr(p_ptr),
    .t_reg(t_reg), .ie(ie)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_state(input logic [1:0] want, input int lim, input string req);
    int n = 0;
    while (state !== want && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk(state === want, req, int'(state), int'(want));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit seen;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    chk(state == S_FETCH, "R1 state", int'(state), 0);
    chk(x_ptr == 0 && p_ptr == 0, "R1 pointers", int'({x_ptr, p_ptr}), 0);
    chk(t_reg == 0, "R1 t_reg", int'(t_reg), 0);
    chk(ie == 0, "R1 ie", int'(ie), 0);

    // R2: fetch/execute alternate on machine-cycle boundaries
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      chk(state == (((k / 8) % 2) ? S_EXEC : S_FETCH), "R2 sequence",
          int'(state), ((k / 8) % 2));
    end

    // R3: held request with ie=0 is never taken
    int_req = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (state == S_INTR) seen = 1'b1;
    end
    chk(!seen, "R3 masked request", int'(seen), 0);
    chk(ie == 0, "R3 ie still clear", int'(ie), 0);

    // R7: writing ie lets the held request in
    ie_we = 1'b1; ie_wd = 1'b1;
    @(negedge clk);
    ie_we = 1'b0;
    chk(ie == 1'b1 || state == S_INTR, "R7 ie write", int'(ie), 1);
    wait_state(S_INTR, 40, "R3 taken after enable");
    int_req = 1'b0;
    wait_state(S_FETCH, 16, "R6 back to fetch");

    // R7/R8: writes on the entry edge lose to the forced values
    instr_done = 1'b0;
    ie_we = 1'b1; ie_wd = 1'b1;
    @(negedge clk);
    ie_we = 1'b0;
    int_req = 1'b1;
    n = 0;
    while (!(state == S_EXEC && ph == 3'd7) && n < 40) begin
      @(negedge clk);
      n++;
    end
    instr_done = 1'b1;
    ie_we = 1'b1; ie_wd = 1'b1;
    x_we = 1'b1; x_wd = 4'h5;
    p_we = 1'b1; p_wd = 4'h6;
    @(negedge clk);
    chk(state == S_INTR, "R7 entry edge state", int'(state), 3);
    chk(ie == 1'b0, "R7 entry beats ie write", int'(ie), 0);
    chk(x_ptr == 4'h2 && p_ptr == 4'h1, "R8 entry beats pointer write",
        int'({x_ptr, p_ptr}), 'h21);
    chk(t_reg == 8'h21, "R4 saved pointers", int'(t_reg), 'h21);
    // R8: writes during the interrupt state are ignored
    x_wd = 4'h9; p_wd = 4'h9;
    @(negedge clk);
    x_we = 1'b0; p_we = 1'b0; ie_we = 1'b0;
    int_req = 1'b0;
    chk(x_ptr == 4'h2 && p_ptr == 4'h1, "R8 pointers held in S3",
        int'({x_ptr, p_ptr}), 'h21);
    chk(ie == 1'b0, "R8 ie held in S3", int'(ie), 0);
    wait_state(S_FETCH, 16, "R6 back to fetch");

    // R9: a multi-cycle instruction defers the interrupt
    ie_we = 1'b1; ie_wd = 1'b1; instr_done = 1'b0;
    @(negedge clk);
    ie_we = 1'b0;
    wait_state(S_EXEC, 16, "R9 reach execute");
    int_req = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (state != S_EXEC) seen = 1'b1;
    end
    chk(!seen, "R9 stays in execute", int'(seen), 0);
    instr_done = 1'b1;
    wait_state(S_INTR, 9, "R9 taken at completion");
    int_req = 1'b0;
    wait_state(S_FETCH, 16, "R6 back to fetch");

    // R4/R5/R6: sweep over every pointer pair
    for (int xv = 0; xv < 16; xv++) begin
      for (int pv = 0; pv < 16; pv++) begin
        wait_state(S_FETCH, 40, "R6 fetch before sweep step");
        x_we = 1'b1; x_wd = 4'(xv);
        p_we = 1'b1; p_wd = 4'(pv);
        ie_we = 1'b1; ie_wd = 1'b1;
        int_req = 1'b1;
        @(negedge clk);
        x_we = 1'b0; p_we = 1'b0; ie_we = 1'b0;
        wait_state(S_INTR, 40, "R3 sweep entry");
        int_req = 1'b0;
        chk(t_reg == 8'(xv * 16 + pv), "R4 t_reg packing", int'(t_reg), xv * 16 + pv);
        chk(x_ptr == 4'h2 && p_ptr == 4'h1, "R5 forced pointers",
            int'({x_ptr, p_ptr}), 'h21);
        chk(ie == 1'b0, "R5 ie cleared", int'(ie), 0);
        n = 0;
        while (state == S_INTR && n < 20) begin
          @(negedge clk);
          n++;
        end
        chk(n == 8, "R6 S3 length", n, 8);
        chk(state == S_FETCH && p_ptr == 4'h1, "R6 resume with P=1",
            int'({state, p_ptr}), 'h01);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule